// File: doc/BRIEF.md
# Frequency-Assisted Carrier Acquisition Controller

This block helps a carrier recovery loop pull in when the initial frequency error is too wide for a phase detector alone. While it is enabled, it takes the stream of derotated I/Q symbols and forms a frequency error estimate from each pair of consecutive symbols. It averages that estimate in a first-order recursive filter and drives a scaled copy of the average as a correction into the loop's centre frequency. The integrator that adds this correction to the loop frequency lies outside the block.

One 7-bit control word holds the correction gain, the averaging time constant and a handover threshold. The gain is clamped to the loop's beta exponent, which keeps the loop stable. Once the filter has settled and the averaged error falls below the threshold, the block stops on its own and the phase detector takes over tracking. It stays stopped until the enable is cleared and set again, or until a loop reset occurs.

The controller has four states:
- IDLE: cleared, with no correction on the output.
- WARM: correcting while the filter settles.
- TRACK: correcting, and comparing the average against the threshold.
- DONE: stopped after handover.

Its transitions are:
- start (IDLE to WARM, when enabled).
- settled (WARM to TRACK, after 2^s filter updates).
- handover (TRACK to DONE, when the magnitude falls below the threshold).
- abort (WARM, TRACK or DONE to IDLE, when the enable is low or the loop is reset).

Top module: `fcarrier_assist`

## Requirements
- R1: After rst_n is asserted low, fd_active is 0 and freq_corr is 0 until the block is started.
- R2: On each accepted symbol that has a predecessor accepted since the start, the error sample is e = I[n-1]*Q[n] - Q[n-1]*I[n]. The first symbol accepted after a start only becomes the predecessor and does not update the filter.
- R3: The filter average A is 0 on entry to WARM. Each error sample updates it as A <= A + ((e - A) >>> s), an arithmetic shift. Here s = 4, 6, 8 or 10 for ctrl[3:2] = 0, 1, 2 or 3.
- R4: While fd_active is 1, freq_corr = A * 2^g as a signed value. While fd_active is 0, freq_corr is 0.
- R5: The gain is g = min(ctrl[6:4], beta_exp), so a programmed gain larger than beta_exp is replaced by beta_exp.
- R6: For the first 2^s filter updates after a start, no threshold decision is made (state WARM). After the update that completes this count, the state becomes TRACK.
- R7: In TRACK, if |A| < 2^(2*DW-1) >> (6 - ctrl[1:0]), the block enters DONE on the next clock and fd_active falls to 0. The selectable thresholds are 1/64, 1/32, 1/16 and 1/8 of full scale.
- R8: DONE persists while enable stays 1, whatever symbols arrive. Clearing enable and setting it again restarts the block from a cleared filter.
- R9: enable low at a clock edge sends the block to IDLE, so fd_active is 0 after that edge.
- R10: loop_rst high at a clock edge sends the block to IDLE and clears the filter, so fd_active is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_rst | input | 1 | Synchronous carrier loop reset |
| enable | input | 1 | Detector enable |
| ctrl | input | 7 | Gain [6:4], time constant [3:2], threshold [1:0] |
| beta_exp | input | 4 | Beta exponent of the loop filter, the gain ceiling |
| sym_vld | input | 1 | Derotated symbol valid |
| sym_i | input | DW | Derotated in-phase sample, signed |
| sym_q | input | DW | Derotated quadrature sample, signed |
| freq_corr | output | 2*DW+8 | Signed centre-frequency correction |
| fd_active | output | 1 | 1 while the detector is correcting |

## Verification
The hardest situation to reach from the ports is the exact handover edge. The state must leave WARM after precisely 2^s updates, and then stop on the first clock at which the decaying average crosses the selected threshold. The bench first drives a quarter-turn rotating phasor, which pushes the average far above every threshold. It then switches to still symbols, so the average decays through the threshold at a cycle that a cycle-level model predicts for each threshold and time constant. A run of all-zero symbols fixes the number of active cycles at 2^s + 2, which pins the settling count exactly.

// File: rtl/fcad_pkg.sv
package fcad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WARM  = 2'd1,
        ST_TRACK = 2'd2,
        ST_DONE  = 2'd3
    } fcad_st_e;

    localparam int SH_MAX = 10;
    localparam int CNT_W  = SH_MAX + 1;

    // time-constant field to IIR shift: 4, 6, 8, 10
    function automatic logic [3:0] tc_shift(input logic [1:0] t);
        return 4'd4 + {1'b0, t, 1'b0};
    endfunction

endpackage

// File: rtl/fcad_xprod.sv
module fcad_xprod #(
    parameter int DW = 8,
    parameter int XW = 2 * DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 vld,
    input  logic signed [DW-1:0] i_cur,
    input  logic signed [DW-1:0] q_cur,
    output logic signed [XW-1:0] err,
    output logic                 have_prev
);
    logic signed [DW-1:0]   i_prv;
    logic signed [DW-1:0]   q_prv;
    logic signed [2*DW-1:0] p_a;
    logic signed [2*DW-1:0] p_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_prv     <= '0;
            q_prv     <= '0;
            have_prev <= 1'b0;
        end else if (clr) begin
            i_prv     <= '0;
            q_prv     <= '0;
            have_prev <= 1'b0;
        end else if (vld) begin
            i_prv     <= i_cur;
            q_prv     <= q_cur;
            have_prev <= 1'b1;
        end
    end

    assign p_a = i_prv * q_cur;
    assign p_b = q_prv * i_cur;
    assign err = XW'(p_a) - XW'(p_b);

endmodule

// File: rtl/fcad_iir.sv
module fcad_iir #(
    parameter int XW = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 upd,
    input  logic [3:0]           shamt,
    input  logic signed [XW-1:0] err,
    output logic signed [XW-1:0] acc
);
    logic signed [XW:0]   diff;
    logic signed [XW:0]   step;
    logic signed [XW-1:0] acc_n;

    assign diff  = (XW+1)'(err) - (XW+1)'(acc);
    assign step  = diff >>> shamt;
    assign acc_n = acc + step[XW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (upd) begin
            acc <= acc_n;
        end
    end

endmodule

// File: rtl/fcad_scale.sv
module fcad_scale #(
    parameter int XW = 17,
    parameter int GW = 3,
    parameter int BW = 4,
    parameter int CW = XW + (1 << GW) - 1
) (
    input  logic                 on,
    input  logic [GW-1:0]        gain,
    input  logic [BW-1:0]        beta_exp,
    input  logic signed [XW-1:0] acc,
    output logic signed [CW-1:0] corr
);
    logic [GW-1:0] g_eff;

    always_comb begin
        if (BW'(gain) > beta_exp) begin
            g_eff = beta_exp[GW-1:0];
        end else begin
            g_eff = gain;
        end
        corr = on ? (CW'(acc) <<< g_eff) : '0;
    end

endmodule

// File: rtl/fcarrier_assist.sv
module fcarrier_assist
    import fcad_pkg::*;
#(
    parameter int DW = 8,
    parameter int GW = 3,
    parameter int BW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          loop_rst,
    input  logic                          enable,
    input  logic [GW+3:0]                 ctrl,
    input  logic [BW-1:0]                 beta_exp,
    input  logic                          sym_vld,
    input  logic signed [DW-1:0]          sym_i,
    input  logic signed [DW-1:0]          sym_q,
    output logic signed [2*DW+(1<<GW)-1:0] freq_corr,
    output logic                          fd_active
);
    localparam int XW  = 2 * DW + 1;
    localparam int CW  = XW + (1 << GW) - 1;
    localparam int FSL = 2 * DW - 1;

    fcad_st_e               state;
    fcad_st_e               state_n;
    logic                   clr;
    logic                   take;
    logic                   upd;
    logic                   have_prev;
    logic signed [XW-1:0]   err;
    logic signed [XW-1:0]   acc;
    logic [XW-1:0]          acc_mag;
    logic [XW-1:0]          thr_val;
    logic [3:0]             shamt;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       cnt_lim;
    logic [GW-1:0]          gain;
    logic [1:0]             tc_sel;
    logic [1:0]             th_sel;

    assign gain    = ctrl[GW+3:4];
    assign tc_sel  = ctrl[3:2];
    assign th_sel  = ctrl[1:0];
    assign shamt   = tc_shift(tc_sel);
    assign cnt_lim = (CNT_W'(1) << shamt) - CNT_W'(1);
    assign thr_val = XW'(1) << (FSL - 6 + int'(th_sel));
    assign acc_mag = acc[XW-1] ? XW'(-acc) : XW'(acc);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // transitions: start, settled, handover, abort
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (enable && !loop_rst) state_n = ST_WARM;
            end
            ST_WARM: begin
                if (loop_rst || !enable)         state_n = ST_IDLE;
                else if (upd && cnt == cnt_lim)  state_n = ST_TRACK;
            end
            ST_TRACK: begin
                if (loop_rst || !enable)         state_n = ST_IDLE;
                else if (acc_mag < thr_val)      state_n = ST_DONE;
            end
            ST_DONE: begin
                if (loop_rst || !enable)         state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        fd_active = (state == ST_WARM) || (state == ST_TRACK);
        clr       = (state == ST_IDLE);
        take      = sym_vld && fd_active;
        upd       = take && have_prev;
    end

    // settling counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (upd && state == ST_WARM) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    fcad_xprod #(.DW(DW), .XW(XW)) u_xprod (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .vld       (take),
        .i_cur     (sym_i),
        .q_cur     (sym_q),
        .err       (err),
        .have_prev (have_prev)
    );

    fcad_iir #(.XW(XW)) u_iir (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .upd   (upd),
        .shamt (shamt),
        .err   (err),
        .acc   (acc)
    );

    fcad_scale #(.XW(XW), .GW(GW), .BW(BW), .CW(CW)) u_scale (
        .on       (fd_active),
        .gain     (gain),
        .beta_exp (beta_exp),
        .acc      (acc),
        .corr     (freq_corr)
    );

endmodule

// File: rtl/fcad_chk.sv
module fcad_chk
    import fcad_pkg::*;
#(
    parameter int XW = 17,
    parameter int CW = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 loop_rst,
    input logic                 enable,
    input logic                 active,
    input logic signed [CW-1:0] corr,
    input fcad_st_e             st,
    input logic signed [XW-1:0] acc,
    input logic [XW-1:0]        mag,
    input logic [XW-1:0]        thr
);

    a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> corr == '0);

    a_r9_enable_low_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !active);

    a_r10_loop_reset_stops: assert property (@(posedge clk) disable iff (!rst_n)
        loop_rst |=> !active);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && enable && !loop_rst) |=> st == ST_DONE);

    a_r7_handover_below: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && $past(st) == ST_TRACK) |-> $past(mag) < $past(thr));

    a_r3_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WARM && $past(st) == ST_IDLE) |-> acc == '0);

endmodule

bind fcarrier_assist fcad_chk #(.XW(XW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop_rst (loop_rst),
    .enable   (enable),
    .active   (fd_active),
    .corr     (freq_corr),
    .st       (state),
    .acc      (acc),
    .mag      (acc_mag),
    .thr      (thr_val)
);

// File: tb/fcarrier_assist_bench.sv
module fcarrier_assist_bench;
    localparam int DW = 8;
    localparam int CW = 2 * DW + 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 loop_rst = 1'b0;
    logic                 enable = 1'b0;
    logic [6:0]           ctrl = '0;
    logic [3:0]           beta = '0;
    logic                 vld = 1'b0;
    logic signed [DW-1:0] si = '0;
    logic signed [DW-1:0] sq = '0;
    logic signed [CW-1:0] corr;
    logic                 active;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    fcarrier_assist u_fcarrier_assist (
        .clk(clk), .rst_n(rst_n), .loop_rst(loop_rst), .enable(enable),
        .ctrl(ctrl), .beta_exp(beta), .sym_vld(vld), .sym_i(si), .sym_q(sq),
        .freq_corr(corr), .fd_active(active)
    );

    // cycle-level model built from the requirements
    int m_st = 0, m_acc = 0, m_cnt = 0, m_pi = 0, m_pq = 0;
    bit m_hp = 0;

    function automatic int shv(input logic [6:0] c);
        return 4 + 2 * int'(c[3:2]);
    endfunction
    function automatic int thv(input logic [6:0] c);
        return 1 << (2 * DW - 1 - 6 + int'(c[1:0]));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_acc <= 0; m_cnt <= 0; m_hp <= 0; m_pi <= 0; m_pq <= 0;
        end else begin
            case (m_st)
                0: begin
                    m_acc <= 0; m_cnt <= 0; m_hp <= 0; m_pi <= 0; m_pq <= 0;
                    if (enable && !loop_rst) m_st <= 1;
                end
                1, 2: begin
                    if (loop_rst || !enable) m_st <= 0;
                    else begin
                        if (vld) begin
                            m_pi <= int'(si); m_pq <= int'(sq); m_hp <= 1;
                            if (m_hp) begin
                                int e;
                                e = m_pi * int'(sq) - m_pq * int'(si);
                                m_acc <= m_acc + ((e - m_acc) >>> shv(ctrl));
                                if (m_st == 1) begin
                                    m_cnt <= m_cnt + 1;
                                    if (m_cnt == (1 << shv(ctrl)) - 1) m_st <= 2;
                                end
                            end
                        end
                        if (m_st == 2 && (m_acc < 0 ? -m_acc : m_acc) < thv(ctrl)) m_st <= 3;
                    end
                end
                default: if (loop_rst || !enable) m_st <= 0;
            endcase
        end
    end

    task automatic chk(input string t, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    task automatic model_check();
        int g, ea, ec;
        g = (int'(ctrl[6:4]) > int'(beta)) ? int'(beta) : int'(ctrl[6:4]);
        ea = (m_st == 1 || m_st == 2) ? 1 : 0;
        ec = ea ? m_acc * (1 << g) : 0;
        chk({tag, " active"}, int'(active), ea);
        chk({tag, " corr"}, int'(corr), ec);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_check();
    endtask

    task automatic set_ctrl(input int gn, input int tc, input int ts, input int b);
        ctrl = {3'(gn), 2'(tc), 2'(ts)};
        beta = 4'(b);
    endtask

    // kind 0: random, 1: zeros, 2: quarter-turn phasor, 3: still symbol
    task automatic feed(input int n, input int kind, input int vpct);
        for (int k = 0; k < n; k++) begin
            vld = (($urandom % 100) < vpct);
            case (kind)
                0: begin si = DW'($urandom); sq = DW'($urandom); end
                1: begin si = '0; sq = '0; end
                2: begin
                    case (k % 4)
                        0: begin si = 8'sd120;  sq = 8'sd0;    end
                        1: begin si = 8'sd0;    sq = 8'sd120;  end
                        2: begin si = -8'sd120; sq = 8'sd0;    end
                        default: begin si = 8'sd0; sq = -8'sd120; end
                    endcase
                end
                default: begin si = 8'sd90; sq = 8'sd40; end
            endcase
            tick();
        end
        vld = 1'b0;
    endtask

    task automatic restart();
        enable = 1'b0; vld = 1'b0; tick();
        enable = 1'b1; tick();
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt_act, a, b, c, d;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 active in reset", int'(active), 0);
        chk("R1 corr in reset", int'(corr), 0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R1 active after reset", int'(active), 0);

        // R2: direct arithmetic of one error sample, s=4, g=7
        tag = "R2";
        set_ctrl(7, 0, 0, 7);
        enable = 1'b1; tick();
        a = 100; b = -50; c = 30; d = 90;
        vld = 1'b1; si = 8'(a); sq = 8'(b); tick();
        si = 8'(c); sq = 8'(d); tick();
        vld = 1'b0;
        chk("R2 first update corr", int'(corr), ((a * d - b * c) >>> 4) * 128);
        feed(60, 0, 80);

        // R5: gain clamp sweep against beta exponent
        tag = "R5";
        for (int gn = 0; gn < 8; gn++) begin
            for (int bt = 0; bt < 10; bt++) begin
                set_ctrl(gn, 0, 0, bt);
                restart();
                feed(14, 0, 100);
            end
        end

        // R3 R4: random symbols for every time constant
        tag = "R3";
        for (int tc = 0; tc < 4; tc++) begin
            set_ctrl(3, tc, 0, 9);
            restart();
            feed((1 << (4 + 2 * tc)) + 60, 0, 85);
        end
        tag = "R4";
        set_ctrl(5, 1, 3, 2);
        restart();
        feed(120, 2, 70);

        // R6: zero symbols, exact settling length
        tag = "R6";
        for (int tc = 0; tc < 4; tc++) begin
            set_ctrl(2, tc, 0, 4);
            enable = 1'b0; vld = 1'b0; tick();
            enable = 1'b1; vld = 1'b1; si = '0; sq = '0;
            cnt_act = 0;
            for (int k = 0; k < (1 << (4 + 2 * tc)) + 6; k++) begin
                tick();
                if (active) cnt_act++;
            end
            vld = 1'b0;
            chk("R6 active cycles", cnt_act, (1 << (4 + 2 * tc)) + 2);
        end

        // R7: pump with phasor then decay through each threshold
        tag = "R7";
        for (int ts = 0; ts < 4; ts++) begin
            set_ctrl(1, 0, ts, 1);
            restart();
            feed(40, 2, 100);
            chk("R7 still active above threshold", int'(active), 1);
            feed(160, 3, 100);
            chk("R7 stopped below threshold", int'(active), 0);
        end

        // R8: sticky after handover, restart clears
        tag = "R8";
        feed(50, 2, 100);
        chk("R8 stays stopped", int'(active), 0);
        enable = 1'b0; tick();
        enable = 1'b1; tick();
        chk("R8 restart active", int'(active), 1);
        chk("R8 restart cleared corr", int'(corr), 0);

        // R9: enable low mid-acquisition
        tag = "R9";
        set_ctrl(4, 1, 0, 6);
        feed(30, 2, 100);
        enable = 1'b0; tick();
        chk("R9 inactive after enable low", int'(active), 0);
        chk("R9 corr zero after enable low", int'(corr), 0);
        enable = 1'b1; feed(20, 0, 100);

        // R10: loop reset mid-acquisition
        tag = "R10";
        feed(30, 2, 100);
        loop_rst = 1'b1; tick();
        chk("R10 inactive after loop reset", int'(active), 0);
        tick();
        loop_rst = 1'b0; tick();
        chk("R10 restarted cleared", int'(corr), 0);
        feed(40, 0, 100);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule